// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive side of an I2C slave at the address phase of a transfer. It takes the raw SCL and SDA levels, passes them through a two-flop synchroniser and finds START and STOP conditions and the SCL edges. After each START it clocks in the first byte, MSB first. It then checks the upper seven bits of that byte against a programmed 7-bit own address.

When the address matches, the block pulls SDA low for the ninth (acknowledge) clock and sets a sticky "addressed" flag. Once the acknowledge clock ends, it loads the transfer-direction flag from the read/write bit. When the address does not match, the block drives nothing and stays silent until the next START. A bus-busy flag reflects the period between a START and a STOP. Data bytes, general call and 10-bit addresses are handled elsewhere.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A START, meaning SDA falls while SCL is high, sets `bus_busy` to 1 and clears `xmit_dir` to 0.
- R2: After a START, the next eight SCL rising edges sample SDA into the address byte, first bit is bit 7 (MSB first).
- R3: The address matches when received bits 7:1 equal `own_addr[6:0]`. Bit 0, the read/write bit, takes no part in the comparison.
- R4: On a match, `sda_pull_low` rises on the SCL falling edge that ends the eighth bit. It falls on the SCL falling edge that ends the ninth bit.
- R5: On a match, `addressed` becomes 1 and stays 1 until a STOP. A repeated START does not clear it.
- R6: On a match, `xmit_dir` takes the value of received bit 0 (1 means read, so the slave transmits) at the end of the acknowledge clock.
- R7: On a mismatch, the block never asserts `sda_pull_low`, and `addressed` and `xmit_dir` keep their values. Further SCL clocks are ignored until the next START.
- R8: A STOP, meaning SDA rises while SCL is high, clears `bus_busy` and `addressed` and releases SDA.
- R9: During and after reset, `sda_pull_low`, `bus_busy`, `xmit_dir` and `addressed` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad (wired-AND bus value) |
| own_addr | input | 7 | Programmed 7-bit slave address |
| sda_pull_low | output | 1 | Enable for the open-drain SDA pull-down |
| bus_busy | output | 1 | Bus is busy between START and STOP |
| xmit_dir | output | 1 | Direction: 1 means slave transmits |
| addressed | output | 1 | Sticky flag: addressed as slave |

## Verification
The assertions assume that SDA only changes while SCL is low, except for START and STOP. They also assume that each SCL level is held for several system clocks, so that every edge reaches the synchronised domain as a single event. The bench drives the bus as an open-drain master that holds each phase for at least five clocks and changes SDA only in the SCL-low phase. The one exception is the SDA edges it drives on purpose to frame START and STOP. It then sweeps all 256 address bytes against several own addresses.

// File: rtl/i2c_am_pkg.sv
// Package: shared types for the I2C slave address matcher.
// Assumes: nothing; types only.
package i2c_am_pkg;

    // Matcher sequencing states
    typedef enum logic [1:0] {
        ST_IGNORE = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACK    = 2'd2,
        ST_HOLD   = 2'd3
    } am_state_t;

    // Bus events found in the synchronised domain, each one cycle wide
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

endpackage

// File: rtl/i2c_am_sync.sv
// Module: multi-stage synchroniser for a group of asynchronous lines.
// Assumes: inputs idle high (I2C pull-up), so the stages reset to 1.
module i2c_am_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;

        // Shift the raw level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], din[g]};
        end

        assign dout[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/i2c_am_detect.sv
// Module: finds START, STOP and SCL edges from synchronised SCL/SDA.
// Assumes: inputs are already synchronised; each level is held for
// at least two clocks so that every edge shows up exactly once.
module i2c_am_detect
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    // Keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Classify edges; SDA edges count only while SCL stays high
    always_comb begin
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
    end

endmodule

// File: rtl/i2c_am_fsm.sv
// Module: address shifter, comparator, acknowledge driver and status flags.
// Assumes: evt comes from i2c_am_detect; START and STOP never coincide.
module i2c_am_fsm
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull_low,
    output logic              bus_busy,
    output logic              xmit_dir,
    output logic              addressed
);

    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W);

    am_state_t          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               hit;

    // Compare the address part of the received byte; bit 0 is the R/W bit
    assign hit = (shreg[FRAME_W-1:1] == own_addr);

    // Sequencing: STOP has priority, START restarts, then per-state work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IGNORE;
            bit_cnt      <= '0;
            shreg        <= '0;
            sda_pull_low <= 1'b0;
            bus_busy     <= 1'b0;
            xmit_dir     <= 1'b0;
            addressed    <= 1'b0;
        end else if (evt.stop) begin
            state        <= ST_IGNORE;
            sda_pull_low <= 1'b0;
            bus_busy     <= 1'b0;
            addressed    <= 1'b0;
        end else if (evt.start) begin
            state        <= ST_ADDR;
            bit_cnt      <= '0;
            shreg        <= '0;
            sda_pull_low <= 1'b0;
            bus_busy     <= 1'b1;
            xmit_dir     <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (evt.scl_rise && bit_cnt != LAST_CNT) begin
                        shreg   <= {shreg[FRAME_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (evt.scl_fall && bit_cnt == LAST_CNT) begin
                        if (hit) begin
                            state        <= ST_ACK;
                            sda_pull_low <= 1'b1;
                            addressed    <= 1'b1;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        state        <= ST_HOLD;
                        sda_pull_low <= 1'b0;
                        xmit_dir     <= shreg[0];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // START leaves the bus busy with the direction cleared (R1)
    p_start_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (bus_busy && !xmit_dir));

    // STOP drops busy, addressed and the SDA pull (R8)
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!bus_busy && !addressed && !sda_pull_low));

    // SDA is only pulled while addressed (R4)
    p_ack_needs_aas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> addressed);

    // The acknowledge pull starts while SCL is low (R4)
    p_ack_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_lvl);

    // The direction is only set to transmit by a matched address (R6)
    p_trx_after_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xmit_dir) |-> addressed);

    // The addressed flag lives inside a busy period (R5)
    p_aas_within_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addressed |-> bus_busy);

endmodule

// File: rtl/i2c_addr_matcher.sv
// Module: top of the I2C slave address matcher.
// Synchronises SCL and SDA, finds bus events and runs the address match.
// Assumes: SCL is much slower than clk (each level held for several clocks).
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sda_pull_low,
    output logic              bus_busy,
    output logic              xmit_dir,
    output logic              addressed
);

    logic [1:0] pins_s;
    bus_evt_t   evt;

    i2c_am_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (pins_s)
    );

    i2c_am_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (pins_s[1]),
        .sda_s (pins_s[0]),
        .evt   (evt)
    );

    i2c_am_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .scl_lvl      (pins_s[1]),
        .sda_lvl      (pins_s[0]),
        .own_addr     (own_addr),
        .sda_pull_low (sda_pull_low),
        .bus_busy     (bus_busy),
        .xmit_dir     (xmit_dir),
        .addressed    (addressed)
    );

    // No pull-down while the bus is idle (R9, R8)
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (!sda_pull_low && !addressed));

endmodule

// File: tb/test_i2c_addr_matcher.sv
`timescale 1ns/1ps
module test_i2c_addr_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own_addr = 7'h00;
    logic       sda_pull_low, bus_busy, xmit_dir, addressed;
    logic       sda_bus;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_low;

    i2c_addr_matcher i_i2c_addr_matcher (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .own_addr     (own_addr),
        .sda_pull_low (sda_pull_low),
        .bus_busy     (bus_busy),
        .xmit_dir     (xmit_dir),
        .addressed    (addressed)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b (own=%h)", tag, got, exp, own_addr);
        end
    endtask

    task automatic do_start();
        sda_m = 1'b0; idle(8);
    endtask

    task automatic do_rstart();
        scl_m = 1'b0; idle(5);
        sda_m = 1'b1; idle(5);
        scl_m = 1'b1; idle(6);
        sda_m = 1'b0; idle(8);
    endtask

    task automatic do_stop();
        scl_m = 1'b0; idle(5);
        sda_m = 1'b0; idle(5);
        scl_m = 1'b1; idle(6);
        sda_m = 1'b1; idle(8);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; idle(5);
            sda_m = b[i]; idle(5);
            scl_m = 1'b1; idle(8);
        end
    endtask

    // Ninth clock with the master released; checks the slave's answer
    task automatic ack_clock(input logic exp_ack);
        scl_m = 1'b0; idle(5);
        sda_m = 1'b1; idle(5);
        chk("R4 ack low phase", sda_pull_low, exp_ack);
        scl_m = 1'b1; idle(8);
        chk("R4 ack high phase", sda_pull_low, exp_ack);
        chk("R4 bus sda during ack", sda_bus, ~exp_ack);
        scl_m = 1'b0; idle(8);
        chk("R4 ack released", sda_pull_low, 1'b0);
    endtask

    // One full address-only transaction with expectations from R1-style rules
    task automatic transact(input logic [7:0] b);
        logic m;
        m = (b[7:1] == own_addr);
        do_start();
        chk("R1 busy after start", bus_busy, 1'b1);
        chk("R1 dir cleared", xmit_dir, 1'b0);
        send_byte(b);
        ack_clock(m);
        chk(m ? "R5 addressed on match" : "R7 no aas on miss", addressed, m);
        chk(m ? "R6 dir from rw bit" : "R7 dir stays 0", xmit_dir, m & b[0]);
        chk("R2 R3 busy through byte", bus_busy, 1'b1);
        do_stop();
        chk("R8 busy cleared", bus_busy, 1'b0);
        chk("R8 aas cleared", addressed, 1'b0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        idle(4);
        chk("R9 reset pull", sda_pull_low, 1'b0);
        chk("R9 reset busy", bus_busy, 1'b0);
        chk("R9 reset dir", xmit_dir, 1'b0);
        chk("R9 reset aas", addressed, 1'b0);
        rst_n = 1'b1;
        idle(6);

        // Full sweeps of every address byte against two own addresses (R2, R3)
        own_addr = 7'h55;
        for (int a = 0; a < 256; a++) transact(a[7:0]);
        own_addr = 7'h2A;
        for (int a = 0; a < 256; a++) transact(a[7:0]);

        // Corner own addresses with a subset of bytes (R3)
        own_addr = 7'h00;
        for (int a = 0; a < 16; a++) transact(a[7:0]);
        own_addr = 7'h7F;
        for (int a = 240; a < 256; a++) transact(a[7:0]);

        // R7: after a miss, a matching byte without START is ignored
        own_addr = 7'h31;
        do_start();
        send_byte({7'h30, 1'b1});
        ack_clock(1'b0);
        send_byte({7'h31, 1'b1});
        ack_clock(1'b0);
        chk("R7 ignored until start aas", addressed, 1'b0);
        chk("R7 ignored until start dir", xmit_dir, 1'b0);
        do_stop();

        // R5: repeated START keeps the sticky flag, clears direction (R1)
        do_start();
        send_byte({7'h31, 1'b1});
        ack_clock(1'b1);
        chk("R6 read sets dir", xmit_dir, 1'b1);
        do_rstart();
        chk("R1 rstart clears dir", xmit_dir, 1'b0);
        chk("R5 rstart keeps aas", addressed, 1'b1);
        send_byte({7'h12, 1'b1});
        ack_clock(1'b0);
        chk("R5 sticky after miss", addressed, 1'b1);
        chk("R7 miss leaves dir", xmit_dir, 1'b0);
        do_stop();
        chk("R8 stop clears aas", addressed, 1'b0);
        chk("R8 stop clears busy", bus_busy, 1'b0);

        report();
    end

endmodule